// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Datapath

This block is a single-clock synchronous static memory with a registered front end and a registered read port. Every access request (address, chip select, write controls, sleep and write data) is captured on a rising clock edge. A write is committed on the following edge, with byte-lane granularity. A read places its word on the output register on that same following edge. Each read therefore costs one capture edge plus one output edge.

The output is qualified by a drive signal that says when the read bus carries valid data. The timing of output turn-off after a deselect has two settings, chosen by a static mode input. In the early setting, turn-off follows the capture of the deselect directly. In the late setting, turn-off is pipelined to the same depth as read data. A sleep input turns the memory off for accesses while keeping its contents. Controls are active high. Data is organised as `LANES` lanes of `LANE_W` bits each, so a 9-bit lane can carry a parity bit.

Top module: `sram_pipe`

## Requirements
- R1: While reset is held and after it is released with no access, `rdrive` is 0 and `rdata` is 0.
- R2: A read captured at edge n (chip select 1, sleep 0, `gwr` 0, `bwe` 0) drives the stored word on `rdata` with `rdrive` 1 after edge n+1. Back-to-back reads stream one word per cycle.
- R3: A write captured with `bwe` 1 and `gwr` 0 updates only lane i (bits `[i*LANE_W +: LANE_W]`) for each `bstb[i]` that is 1. All other lanes keep their contents.
- R4: A write captured with `gwr` 1 updates every lane, whatever `bwe` and `bstb` are.
- R5: With chip select 1 and both `bwe` and `gwr` 0, the strobes `bstb` are ignored. The access is a read and memory is unchanged.
- R6: With `dcd_mode` 0, a deselect (chip select 0) captured at edge n forces `rdrive` to 0 after edge n, even when edge n completes a read.
- R7: With `dcd_mode` 1, a deselect captured at edge n right after a read still lets that read drive after edge n. `rdrive` falls after edge n+1.
- R8: A sleep captured at edge n is treated as no access: no write happens, no read happens, and `rdrive` is 0 after edge n in both modes. Stored data is retained.
- R9: `rdata` is all zeros whenever `rdrive` is 0.
- R10: A write captured at edge n produces no drive after edge n+1.
- R11: A read captured at the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| sel | input | 1 | Chip select; 0 is a deselect |
| addr | input | ADDR_W | Word address |
| bwe | input | 1 | Byte-write enable, qualifies `bstb` |
| bstb | input | LANES | Per-lane write strobes |
| gwr | input | 1 | Global write: all lanes |
| sleep | input | 1 | Low-power request; accesses ignored |
| dcd_mode | input | 1 | 0: early output turn-off, 1: turn-off pipelined like reads |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driving |
| rdrive | output | 1 | Read bus valid/drive |

## Verification
The bench builds the block with `ADDR_W` = 4 and `LANE_W` = 9, keeping four lanes. This makes a 36-bit word whose ninth bit per lane exercises the lane slicing at a width that is not a byte. The 16-word depth keeps the reference model small, while address reuse still reaches the write-then-read case. Both deselect modes are switched at run time within one build, so the early and late turn-off edges are compared cycle by cycle against the scoreboard.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SLEEP = 2'd3
    } sram_op_e;
endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      bwe,
    input  logic [LANES-1:0]          bstb,
    input  logic                      gwr,
    input  logic                      sleep,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output sram_op_e                  op_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES-1:0]          lanes_q,
    output logic [LANES*LANE_W-1:0]   wdata_q
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        sram_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    lanes;
        logic [DATA_W-1:0]   wdata;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    // Decode priority: sleep, then deselect, then global write, then byte write, else read.
    always_comb begin
        cmd_d.addr  = addr;
        cmd_d.wdata = wdata;
        cmd_d.lanes = '0;
        if (sleep) begin
            cmd_d.op = OP_SLEEP;
        end else if (!sel) begin
            cmd_d.op = OP_DESEL;
        end else if (gwr) begin
            cmd_d.op    = OP_WRITE;
            cmd_d.lanes = '1;
        end else if (bwe) begin
            cmd_d.op    = OP_WRITE;
            cmd_d.lanes = bstb;
        end else begin
            cmd_d.op = OP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{op: OP_DESEL, addr: '0, lanes: '0, wdata: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign op_q    = cmd_q.op;
    assign addr_q  = cmd_q.addr;
    assign lanes_q = cmd_q.lanes;
    assign wdata_q = cmd_q.wdata;

    assert_sleep_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (op_q == OP_SLEEP && lanes_q == '0));

    assert_global_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && gwr && !sleep) |=> (op_q == OP_WRITE && lanes_q == {LANES{1'b1}}));

    assert_strobe_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sleep && !gwr && !bwe) |=> (op_q == OP_READ && lanes_q == '0));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          we_lanes,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[g]) begin
                mem_q[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem_q[addr];
    end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pipe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dcd_mode,
    input  sram_op_e            op,
    input  logic [DATA_W-1:0]   rd_word,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdrive
);
    typedef struct packed {
        logic                drive;
        logic [DATA_W-1:0]   data;
    } out_t;

    out_t out_d, out_q;
    logic cut;

    always_comb begin
        out_d.drive = (op == OP_READ);
        out_d.data  = (op == OP_READ) ? rd_word : '0;
        // Early turn-off: captured sleep always, captured deselect only in early mode.
        cut    = (op == OP_SLEEP) || (!dcd_mode && op == OP_DESEL);
        rdrive = out_q.drive && !cut;
        rdata  = rdrive ? out_q.data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op == OP_READ) && op == OP_READ) |-> rdrive);

    assert_early_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dcd_mode && op == OP_DESEL) |-> !rdrive);

    assert_late_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_mode && op == OP_DESEL && $past(op == OP_READ)) |-> rdrive);

    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SLEEP) |-> !rdrive);
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      bwe,
    input  logic [LANES-1:0]          bstb,
    input  logic                      gwr,
    input  logic                      sleep,
    input  logic                      dcd_mode,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdrive
);
    localparam int DATA_W = LANES * LANE_W;

    sram_op_e            op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LANES-1:0]    lanes_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rd_word;

    sram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .addr    (addr),
        .bwe     (bwe),
        .bstb    (bstb),
        .gwr     (gwr),
        .sleep   (sleep),
        .wdata   (wdata),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .lanes_q (lanes_q),
        .wdata_q (wdata_q)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk      (clk),
        .addr     (addr_q),
        .we_lanes (lanes_q),
        .wdata    (wdata_q),
        .rd_word  (rd_word)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .dcd_mode (dcd_mode),
        .op       (op_q),
        .rd_word  (rd_word),
        .rdata    (rdata),
        .rdrive   (rdrive)
    );

    assert_read_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdrive |-> (rdata == $past(rd_word)));

    assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_q == OP_WRITE) |-> !rdrive);

    assert_quiet_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdrive) |-> (rdata == '0));
endmodule

// File: tb/sim_sram_pipe.sv
module sim_sram_pipe;
    localparam int PERIOD = 10;
    localparam int AW = 4;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic clk = 0, rst_n = 0;
    logic sel = 0, bwe = 0, gwr = 0, sleep = 0, dcd_mode = 0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] bstb = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdrive;

    int checks = 0, fails = 0;
    logic [DW-1:0] refm [1<<AW];
    logic          q_drive [$];
    logic [DW-1:0] q_data [$];
    string         q_tag [$];
    int p_op = 0;
    logic [AW-1:0] p_addr = '0;
    logic [LN-1:0] p_lanes = '0;
    logic [DW-1:0] p_wdata = '0;

    sram_pipe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .bwe(bwe), .bstb(bstb),
        .gwr(gwr), .sleep(sleep), .dcd_mode(dcd_mode), .wdata(wdata),
        .rdata(rdata), .rdrive(rdrive)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one access per cycle; predicts outputs after the coming edge.
    task automatic issue(logic s, logic [AW-1:0] a, logic be, logic [LN-1:0] st,
                         logic g, logic sl, logic dm, logic [DW-1:0] wd, string tag);
        int cur;
        logic dr;
        @(negedge clk);
        sel = s; addr = a; bwe = be; bstb = st; gwr = g; sleep = sl; dcd_mode = dm; wdata = wd;
        if (sl) cur = 3;
        else if (!s) cur = 0;
        else if (g || be) cur = 2;
        else cur = 1;
        if (p_op == 2) begin
            for (int l = 0; l < LN; l++)
                if (p_lanes[l]) refm[p_addr][l*LW +: LW] = p_wdata[l*LW +: LW];
        end
        dr = (p_op == 1) && (cur != 3) && !(!dm && cur == 0);
        q_drive.push_back(dr);
        q_data.push_back(dr ? refm[p_addr] : '0);
        q_tag.push_back(tag);
        p_op = cur; p_addr = a; p_wdata = wd;
        p_lanes = (cur == 2) ? (g ? {LN{1'b1}} : st) : '0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic dm, string tag);
        issue(1, a, 0, '0, 0, 0, dm, '0, tag);
    endtask
    task automatic idle(logic dm, string tag);
        issue(0, '0, 0, '0, 0, 0, dm, '0, tag);
    endtask

    // Monitor: compares after each edge against the oldest prediction.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_drive.size() > 0) begin
                logic d;
                logic [DW-1:0] v;
                string t;
                d = q_drive.pop_front();
                v = q_data.pop_front();
                t = q_tag.pop_front();
                check({t, " drive"}, {{(DW-1){1'b0}}, rdrive}, {{(DW-1){1'b0}}, d});
                check({t, " data"}, rdata, v);
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset drive", {{(DW-1){1'b0}}, rdrive}, '0);
        check("R1 in reset data", rdata, '0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release drive", {{(DW-1){1'b0}}, rdrive}, '0);
        check("R1 after release data", rdata, '0);

        // R4: global writes ignore bwe/bstb
        issue(1, 4'd0, 0, 4'b0000, 1, 0, 0, 36'h1_2345_6789, "R4 gw0");
        issue(1, 4'd1, 1, 4'b0001, 1, 0, 0, 36'hF_EDCB_A987, "R4 gw1");
        issue(1, 4'd2, 0, 4'b0000, 1, 0, 0, 36'hA_5A5A_5A5A, "R10 gw2");
        issue(1, 4'd3, 0, 4'b1010, 1, 0, 0, 36'h0_F0F0_F0F0, "R10 gw3");
        // R2: streamed reads
        rd(4'd0, 0, "R10 rd0");
        rd(4'd1, 0, "R2 rd1");
        rd(4'd2, 0, "R2 rd2");
        rd(4'd3, 0, "R2 rd3");
        idle(0, "R2 tail");
        // R3: byte writes on lanes 0 and 2 of word 1
        issue(1, 4'd1, 1, 4'b0101, 0, 0, 0, 36'h0_0000_0000, "R9 bw");
        rd(4'd1, 0, "R10 rd1");
        idle(1, "R3 lanes 0,2");
        // R5: strobes without bwe are a read, no write
        issue(1, 4'd2, 0, 4'b1111, 0, 0, 0, 36'hF_FFFF_FFFF, "R9 strobe");
        rd(4'd2, 1, "R5 strobe read");
        idle(1, "R5 unchanged");
        // R11: write then immediate read of same word
        issue(1, 4'd5, 0, '0, 1, 0, 0, 36'h3_1415_9265, "R9 w5");
        rd(4'd5, 0, "R10 rd5");
        rd(4'd5, 0, "R11 new data");
        // R6: early turn-off cuts a completing read
        rd(4'd0, 0, "R2 rd0");
        idle(0, "R6 early cut");
        idle(0, "R9 quiet");
        // R7: late turn-off lets read finish
        rd(4'd3, 1, "R9 rd3");
        idle(1, "R7 late keep");
        idle(1, "R7 late off");
        // R8: sleep ignores writes and reads
        rd(4'd0, 1, "R9 rd0");
        issue(1, 4'd0, 0, '0, 1, 1, 1, 36'h0_0000_0001, "R8 sleep cut dcd");
        issue(1, 4'd0, 0, '0, 0, 1, 0, '0, "R8 sleep no out");
        rd(4'd0, 0, "R8 no read");
        rd(4'd1, 0, "R8 data kept");
        issue(1, 4'd1, 0, '0, 0, 1, 0, '0, "R8 sleep cut scd");
        idle(0, "R9 end");
        idle(0, "R9 end");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule